// File: doc/BRIEF.md
# Linked Descriptor Fetch Unit

This block serves one DMA channel that works from a chain of descriptors held in memory. When the channel asks for its next descriptor, the block reads four 32-bit words from memory and loads them into the channel's working registers. The four words are, in memory order, the link to the following descriptor, the source address, the target address and the command word. The block does not move data, evaluate compare results or combine interrupts. It only locates and loads descriptors.

The fetch address comes from the channel's current link pointer with its low four bits cleared. If bit 1 of that pointer (branch enable) is set and the compare status input is high, the block adds 32 bytes to that address and reads the alternate descriptor. For flow-controlled transfers, the block aligns the loaded source and target addresses to a word. When the command asks for a start notice, the block raises a start flag together with the completion strobe.

The block talks to memory over a single-beat read handshake: `rd_req_o` and `rd_addr_o` stay steady until `rd_ack_i` returns the data. The control flow is a three-state machine:
- **IDLE**: waits for `start_i`.
- **FETCH**: issues four reads. Each `rd_ack_i` captures one word, and the fourth ack commits the descriptor.
- **DONE**: one cycle that carries `done_o`, then returns to **IDLE**.

The transitions are:
- IDLE→FETCH on start.
- FETCH→FETCH on each ack that is not the last.
- FETCH→DONE on the last ack.
- DONE→IDLE always.

Top module: `desc_fetch_unit`

## Requirements
- R1: After reset the block is in IDLE: `rd_req_o`, `done_o`, `busy_o` and `start_set_o` are 0, and all four loaded registers are 0.
- R2: A fetch issues exactly four reads, at fetch address +0, +4, +8 and +12 in that order. Each read holds `rd_req_o` high with a steady, word-aligned `rd_addr_o` until the cycle in which `rd_ack_i` is high.
- R3: The fetch address is `cur_ptr_i` with bits [3:0] cleared. `cur_ptr_i` is sampled in the cycle `start_i` is accepted.
- R4: When `cur_ptr_i[1]` is 1 and `cmp_stat_i` is 1 at start, the fetch address is increased by 32.
- R5: When either `cur_ptr_i[1]` or `cmp_stat_i` is 0 at start, no offset is added.
- R6: The words at +0, +4, +8 and +12 load `next_ptr_o`, `src_addr_o`, `dst_addr_o` and `cmd_o`. `next_ptr_o` keeps every bit of the word, including bit 0, the end-of-chain mark.
- R7: When bit 29 of the loaded command (source flow control) is 1, `src_addr_o[1:0]` is loaded as 0. Otherwise the source word is loaded unchanged.
- R8: When bit 28 of the loaded command (target flow control) is 1, `dst_addr_o[1:0]` is loaded as 0. Otherwise the target word is loaded unchanged.
- R9: `start_set_o` is high in the DONE cycle exactly when bit 22 of the loaded command is 1. It is never high outside DONE.
- R10: `done_o` is high for exactly one cycle, the cycle after the fourth ack. `busy_o` is high from the cycle after start is accepted through the DONE cycle.
- R11: A `start_i` pulse while `busy_o` is high is ignored. The fetch in progress keeps its address and produces exactly one `done_o`.
- R12: The four loaded registers do not change until all four words have arrived. They change only at the edge that enters DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to fetch the next descriptor |
| cur_ptr_i | input | 32 | Channel's current link pointer |
| cmp_stat_i | input | 1 | Channel compare status; selects the branch slot |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 32 | Memory read byte address |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | 32 | Read data |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle completion strobe |
| start_set_o | output | 1 | Start flag set request, valid with `done_o` |
| next_ptr_o | output | 32 | Loaded link to the following descriptor |
| src_addr_o | output | 32 | Loaded source address |
| dst_addr_o | output | 32 | Loaded target address |
| cmd_o | output | 32 | Loaded command word |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and data, a 16-byte descriptor alignment and a 32-byte branch offset. With these values, random pointers carry arbitrary low bits, so both the nibble clearing and the branch offset are exercised. A random command word reaches every combination of the two flow-control bits and the start-notice bit. The memory responder inserts zero to two wait cycles before each ack, which exercises the hold behaviour of the handshake. Some runs inject a second start in the middle of a fetch, with a different pointer, to show that it is ignored.

// File: rtl/dfu_pkg.sv
package dfu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } dfu_state_e;

    localparam int DESC_WORDS   = 4;
    localparam int WI_NEXT      = 0;
    localparam int WI_SRC       = 1;
    localparam int WI_DST       = 2;
    localparam int WI_CMD       = 3;
    localparam int PTR_BRANCH   = 1;
    localparam int CMD_SRC_FLOW = 29;
    localparam int CMD_DST_FLOW = 28;
    localparam int CMD_START_IE = 22;
endpackage

// File: rtl/dfu_addr_gen.sv
module dfu_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_LSB  = 4,
    parameter int BRANCH_OFS = 32,
    parameter int BRANCH_BIT = 1
) (
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic              cmp_i,
    output logic [ADDR_W-1:0] base_o
);
    localparam logic [ADDR_W-1:0] CLR_MASK = ~((ADDR_W'(1) << ALIGN_LSB) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] OFS      = ADDR_W'(BRANCH_OFS);

    logic take_branch;

    always_comb begin
        take_branch = ptr_i[BRANCH_BIT] & cmp_i;
        base_o      = (ptr_i & CLR_MASK) + (take_branch ? OFS : '0);
    end
endmodule

// File: rtl/dfu_desc_sanitize.sv
module dfu_desc_sanitize #(
    parameter int DATA_W     = 32,
    parameter int FLOW_ALIGN = 2
) (
    input  logic [DATA_W-1:0] src_raw_i,
    input  logic [DATA_W-1:0] dst_raw_i,
    input  logic              src_flow_i,
    input  logic              dst_flow_i,
    output logic [DATA_W-1:0] src_o,
    output logic [DATA_W-1:0] dst_o
);
    localparam logic [DATA_W-1:0] WORD_MASK = ~((DATA_W'(1) << FLOW_ALIGN) - DATA_W'(1));

    always_comb begin
        src_o = src_flow_i ? (src_raw_i & WORD_MASK) : src_raw_i;
        dst_o = dst_flow_i ? (dst_raw_i & WORD_MASK) : dst_raw_i;
    end
endmodule

// File: rtl/desc_fetch_unit.sv
module desc_fetch_unit
    import dfu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int ALIGN_LSB  = 4,
    parameter int BRANCH_OFS = 32,
    parameter int FLOW_ALIGN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] cur_ptr_i,
    input  logic              cmp_stat_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              start_set_o,
    output logic [DATA_W-1:0] next_ptr_o,
    output logic [DATA_W-1:0] src_addr_o,
    output logic [DATA_W-1:0] dst_addr_o,
    output logic [DATA_W-1:0] cmd_o
);
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int BYTE_SHIFT = $clog2(DATA_W / 8);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    dfu_state_e state_q, state_d;

    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] fetch_base;
    logic [DATA_W-1:0] words_q [DESC_WORDS-1];
    logic [DATA_W-1:0] desc_w  [DESC_WORDS];
    logic [DATA_W-1:0] src_clean, dst_clean;
    logic              start_q;
    logic              accept, beat, last_beat;

    dfu_addr_gen #(
        .ADDR_W    (ADDR_W),
        .ALIGN_LSB (ALIGN_LSB),
        .BRANCH_OFS(BRANCH_OFS),
        .BRANCH_BIT(PTR_BRANCH)
    ) addr_gen_i (
        .ptr_i (cur_ptr_i),
        .cmp_i (cmp_stat_i),
        .base_o(fetch_base)
    );

    // Present the descriptor being committed: stored words plus the live last word.
    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_desc
        if (g == DESC_WORDS - 1) begin : g_live
            assign desc_w[g] = rd_data_i;
        end else begin : g_held
            assign desc_w[g] = words_q[g];
        end
    end

    dfu_desc_sanitize #(
        .DATA_W    (DATA_W),
        .FLOW_ALIGN(FLOW_ALIGN)
    ) sanitize_i (
        .src_raw_i (desc_w[WI_SRC]),
        .dst_raw_i (desc_w[WI_DST]),
        .src_flow_i(desc_w[WI_CMD][CMD_SRC_FLOW]),
        .dst_flow_i(desc_w[WI_CMD][CMD_DST_FLOW]),
        .src_o     (src_clean),
        .dst_o     (dst_clean)
    );

    always_comb begin
        accept    = (state_q == ST_IDLE) && start_i;
        beat      = (state_q == ST_FETCH) && rd_ack_i;
        last_beat = beat && (idx_q == LAST_IDX);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)   state_d = ST_FETCH;
            ST_FETCH: if (last_beat) state_d = ST_DONE;
            ST_DONE:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= '0;
            base_q     <= '0;
            start_q    <= 1'b0;
            next_ptr_o <= '0;
            src_addr_o <= '0;
            dst_addr_o <= '0;
            cmd_o      <= '0;
            for (int i = 0; i < DESC_WORDS - 1; i++) words_q[i] <= '0;
        end else begin
            if (accept) begin
                base_q <= fetch_base;
                idx_q  <= '0;
            end
            if (beat && !last_beat) begin
                words_q[idx_q] <= rd_data_i;
                idx_q          <= idx_q + 1'b1;
            end
            if (last_beat) begin
                next_ptr_o <= desc_w[WI_NEXT];
                src_addr_o <= src_clean;
                dst_addr_o <= dst_clean;
                cmd_o      <= desc_w[WI_CMD];
                start_q    <= desc_w[WI_CMD][CMD_START_IE];
            end
        end
    end

    // Outputs
    always_comb begin
        rd_req_o    = 1'b0;
        done_o      = 1'b0;
        busy_o      = 1'b0;
        start_set_o = 1'b0;
        rd_addr_o   = base_q + (ADDR_W'(idx_q) << BYTE_SHIFT);
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: begin
                rd_req_o = 1'b1;
                busy_o   = 1'b1;
            end
            ST_DONE: begin
                done_o      = 1'b1;
                busy_o      = 1'b1;
                start_set_o = start_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dfu_chk.sv
module dfu_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_ack_i,
    input logic              done_o,
    input logic              busy_o,
    input logic              start_set_o,
    input logic [DATA_W-1:0] next_ptr_o,
    input logic [DATA_W-1:0] src_addr_o,
    input logic [DATA_W-1:0] dst_addr_o,
    input logic [DATA_W-1:0] cmd_o
);
    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));

    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> rd_addr_o[1:0] == 2'b00);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rd_req_o && rd_ack_i));

    // R10
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o && !rd_req_o);

    // R9
    start_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_set_o |-> done_o);

    // R12
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(next_ptr_o) && $stable(src_addr_o)
                    && $stable(dst_addr_o) && $stable(cmd_o));

    // R7
    src_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && cmd_o[29] |-> src_addr_o[1:0] == 2'b00);

    // R8
    dst_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && cmd_o[28] |-> dst_addr_o[1:0] == 2'b00);
endmodule

bind desc_fetch_unit dfu_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_ack_i   (rd_ack_i),
    .done_o     (done_o),
    .busy_o     (busy_o),
    .start_set_o(start_set_o),
    .next_ptr_o (next_ptr_o),
    .src_addr_o (src_addr_o),
    .dst_addr_o (dst_addr_o),
    .cmd_o      (cmd_o)
);

// File: tb/desc_fetch_unit_tb_top.sv
`timescale 1ns/1ps
module desc_fetch_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] cur_ptr_i = '0;
    logic        cmp_stat_i = 1'b0;
    logic        rd_req_o;
    logic [31:0] rd_addr_o;
    logic        rd_ack_i = 1'b0;
    logic [31:0] rd_data_i = '0;
    logic        busy_o, done_o, start_set_o;
    logic [31:0] next_ptr_o, src_addr_o, dst_addr_o, cmd_o;

    always #2.5 clk = ~clk;

    desc_fetch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cur_ptr_i(cur_ptr_i),
        .cmp_stat_i(cmp_stat_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
        .done_o(done_o), .start_set_o(start_set_o), .next_ptr_o(next_ptr_o),
        .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o), .cmd_o(cmd_o)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [31:0] salt = '0;
    bit          force_en = 1'b0;
    logic [31:0] force_cmd = '0;
    logic [31:0] rec_addr [8];
    int          rec_n = 0;
    int          wait_cnt = 0;
    int          done_cnt = 0;
    int          early_change = 0;
    int          start_set_cnt = 0;
    bit          watching = 1'b0;
    logic [31:0] hold_next = '0;

    function automatic logic [31:0] memf(input logic [31:0] a);
        if (force_en && a[3:0] == 4'hC) return force_cmd;
        return {a[15:0] ^ salt[31:16], a[15:0] + salt[15:0]};
    endfunction

    function automatic logic [31:0] exp_base(input logic [31:0] p, input logic c);
        return (p & 32'hFFFF_FFF0) + ((p[1] && c) ? 32'd32 : 32'd0);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory responder: 0..2 wait cycles, ack for one cycle.
    always @(negedge clk) begin
        if (!rst_n) begin
            rd_ack_i <= 1'b0;
            wait_cnt = 0;
        end else if (rd_ack_i) begin
            rd_ack_i <= 1'b0;
        end else if (rd_req_o) begin
            if (wait_cnt == 0) begin
                rd_ack_i  <= 1'b1;
                rd_data_i <= memf(rd_addr_o);
                if (rec_n < 8) rec_addr[rec_n] = rd_addr_o;
                rec_n++;
                wait_cnt = $urandom_range(0, 2);
            end else begin
                wait_cnt--;
            end
        end
    end

    // Monitor for strobes and premature register updates.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) done_cnt++;
            if (start_set_o && !done_o) start_set_cnt++;
            if (watching && !done_o && next_ptr_o !== hold_next) early_change++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run(input logic [31:0] ptr, input logic cmp, input bit inject);
        logic [31:0] b, w0, w1, w2, w3, es, ed;
        int n;
        b  = exp_base(ptr, cmp);
        w0 = memf(b); w1 = memf(b + 4); w2 = memf(b + 8); w3 = memf(b + 12);
        es = w3[29] ? (w1 & 32'hFFFF_FFFC) : w1;
        ed = w3[28] ? (w2 & 32'hFFFF_FFFC) : w2;
        @(negedge clk);
        cur_ptr_i = ptr; cmp_stat_i = cmp; start_i = 1'b1;
        rec_n = 0; done_cnt = 0; early_change = 0; start_set_cnt = 0;
        hold_next = next_ptr_o; watching = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R10", "busy after start", {31'd0, busy_o}, 32'd1);
        if (inject) begin
            @(negedge clk);
            cur_ptr_i = ptr ^ 32'h0000_0FF2; cmp_stat_i = ~cmp; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        n = 0;
        while (!done_o && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(done_o === 1'b1, "R10", "done reached", {31'd0, done_o}, 32'd1);
        watching = 1'b0;
        check(rec_n == 4, "R2", "read count", rec_n, 32'd4);
        check(rec_addr[0] == b, inject ? "R11" : ((ptr[1] && cmp) ? "R4" : "R3"),
              "fetch address", rec_addr[0], b);
        for (int k = 1; k < 4; k++)
            check(rec_addr[k] == b + 32'(4 * k), "R2", "word address", rec_addr[k], b + 32'(4 * k));
        check(next_ptr_o == w0, "R6", "next pointer", next_ptr_o, w0);
        check(cmd_o == w3, "R6", "command", cmd_o, w3);
        check(src_addr_o == es, "R7", "source", src_addr_o, es);
        check(dst_addr_o == ed, "R8", "target", dst_addr_o, ed);
        check(start_set_o === w3[22], "R9", "start flag", {31'd0, start_set_o}, {31'd0, w3[22]});
        check(early_change == 0, "R12", "early register update", early_change, 32'd0);
        @(negedge clk);
        check(done_o === 1'b0 && busy_o === 1'b0, "R10", "done one cycle",
              {30'd0, done_o, busy_o}, 32'd0);
        check(done_cnt == 1, inject ? "R11" : "R10", "done count", done_cnt, 32'd1);
        check(start_set_cnt == 0, "R9", "start flag outside done", start_set_cnt, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rd_req_o === 1'b0, "R1", "req in reset", {31'd0, rd_req_o}, 32'd0);
        check(done_o === 1'b0 && busy_o === 1'b0 && start_set_o === 1'b0, "R1",
              "strobes in reset", {29'd0, done_o, busy_o, start_set_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(next_ptr_o === 32'd0 && src_addr_o === 32'd0, "R1", "next/src after reset",
              next_ptr_o | src_addr_o, 32'd0);
        check(dst_addr_o === 32'd0 && cmd_o === 32'd0, "R1", "dst/cmd after reset",
              dst_addr_o | cmd_o, 32'd0);
        check(busy_o === 1'b0, "R1", "idle after reset", {31'd0, busy_o}, 32'd0);

        // R3 alignment, no branch
        salt = 32'h1234_0001; force_en = 1'b0;
        run(32'h0000_100D, 1'b1, 1'b0);
        // R4 branch taken
        run(32'h0000_2002, 1'b1, 1'b0);
        // R5 branch enable set, compare clear
        run(32'h0000_3002, 1'b0, 1'b0);
        // R5 compare set, branch enable clear
        run(32'h0000_400D, 1'b1, 1'b0);
        // R6 end-of-chain bit kept: salt low 1 makes word 0 odd
        run(32'h0000_1000, 1'b0, 1'b0);
        check(next_ptr_o[0] === 1'b1, "R6", "end-of-chain bit", {31'd0, next_ptr_o[0]}, 32'd1);
        // R7 R8 R9 flow-control and start notice forced on
        force_en = 1'b1; force_cmd = 32'h3040_0000; salt = 32'hABCD_0003;
        run(32'h0000_5000, 1'b0, 1'b0);
        // R7 R8 R9 all off, unaligned addresses kept
        force_cmd = 32'h0000_1234;
        run(32'h0000_6000, 1'b0, 1'b0);
        // R11 start during fetch
        force_en = 1'b0;
        run(32'h0000_7006, 1'b1, 1'b1);

        for (int i = 0; i < 40; i++) begin
            salt = $urandom;
            force_en = ($urandom_range(0, 2) == 0);
            force_cmd = $urandom;
            run($urandom, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule